// File: doc/BRIEF.md
# SDRAM write burst engine

This block models the device-side write path of a single-data-rate SDRAM with four banks. It watches the command pins on each rising clock. When they encode a WRITE, it latches the target bank, the starting column and the auto-precharge flag. It also stores the word on the data input at the starting column in that same edge, with no latency.

Each later edge stores the next word at the next column of the burst. A burst is 1, 2, 4 or 8 words long, or runs as a full page. Fixed bursts wrap inside their aligned block of columns. A full-page burst wraps from column 255 to column 0 and runs until another WRITE ends it. A new WRITE on any cycle cuts the burst in progress short and starts its own burst with the data presented alongside it.

When a burst that asked for auto precharge runs to completion, the block raises a one-cycle precharge request that carries the bank. Every accepted word is also presented on a write strobe with its bank, column and data. A small per-bank array stands in for the memory cells, and a read port lets the array be inspected.

Top module: `sdr_wr_burst`

## Requirements
- R1: A WRITE is sampled at a rising edge when cke=1, cs_n=0, ras_n=1, cas_n=0 and we_n=0. Any other pin combination, including we_n=1 or cs_n=1, starts no burst and stores nothing.
- R2: On the edge that samples a WRITE, the word on dq_in is stored at column addr[7:0] of bank ba[1:0]. During that cycle wr_vld=1, wr_col=addr[7:0] and wr_bank=ba.
- R3: Each following cycle of a burst stores the word on dq_in at the burst's next column, with wr_vld=1.
- R4: burst_sel selects the burst length: 0 gives 1 word, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives a full page, and 4 to 6 give 1 word. A fixed burst of length L steps through the columns by incrementing only the low log2(L) bits, so it wraps inside its aligned block of L columns.
- R5: Once a fixed burst has stored its last word and no new WRITE arrives, wr_vld stays 0 and the data on dq_in is not stored.
- R6: A full-page burst (burst_sel=7) keeps storing one word per cycle, stepping from column 255 to column 0, until a new WRITE arrives.
- R7: A WRITE arriving on any cycle, to the same bank or to another bank, ends the current burst. The word presented with it belongs to the new burst, and there is no gap cycle.
- R8: If addr[10]=1 with the WRITE, pre_req is 1 for exactly one cycle, the cycle after the burst's last word, and pre_bank holds the burst's bank. If addr[10]=0, pre_req stays 0.
- R9: A burst ended by a new WRITE, including a full-page burst, produces no pre_req pulse.
- R10: While cke=0, no command is sampled. A burst in progress holds its position and stores nothing, then resumes at the same column when cke returns to 1.
- R11: While rst_n=0, and after it is released, no burst is active: wr_vld=0 with a NOP on the pins, and pre_req=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low pauses sampling |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write enable command pin |
| ba | input | 2 | Bank address |
| addr | input | 11 | Column in bits 7:0, auto-precharge flag in bit 10 |
| burst_sel | input | 3 | Burst length code |
| dq_in | input | 32 | Write data |
| wr_vld | output | 1 | Word accepted this cycle |
| wr_bank | output | 2 | Bank of the accepted word |
| wr_col | output | 8 | Column of the accepted word |
| wr_data | output | 32 | Accepted word |
| pre_req | output | 1 | Precharge request pulse |
| pre_bank | output | 2 | Bank to precharge |
| rd_bank | input | 2 | Inspection read bank |
| rd_col | input | 8 | Inspection read column |
| rd_data | output | 32 | Array contents at rd_bank/rd_col |

## Verification
The assertions assume that the command pins, data and burst_sel change only away from the rising edge. They also assume the pins encode a NOP or a deselect whenever no WRITE is meant, and in particular while reset is applied. The full-page step and precharge checks further assume that wr_col and wr_vld in the previous cycle came from the same, uninterrupted burst. The stimulus meets these assumptions in two ways. It changes every input on the falling edge and leaves a NOP on the pins between commands. It also asserts reset only while the pins carry a NOP.

// File: rtl/sdr_wr_pkg.sv
package sdr_wr_pkg;
    localparam int COL_W  = 8;
    localparam int BANK_W = 2;
    localparam int NBANK  = 1 << BANK_W;
    localparam int NCOL   = 1 << COL_W;
    localparam int CNT_W  = 4;
    localparam int BSEL_W = 3;
    localparam logic [BSEL_W-1:0] SEL_PAGE = 3'd7;

    typedef struct packed {
        logic              active;
        logic              full;
        logic              ap;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [COL_W-1:0]  mask;
        logic [CNT_W-1:0]  remain;
        logic              pre;
        logic [BANK_W-1:0] pre_bank;
    } burst_t;

    function automatic logic [COL_W-1:0] blk_mask(input logic [BSEL_W-1:0] sel);
        case (sel)
            3'd1:     return COL_W'(1);
            3'd2:     return COL_W'(3);
            3'd3:     return COL_W'(7);
            SEL_PAGE: return '1;
            default:  return '0;
        endcase
    endfunction

    function automatic logic [COL_W-1:0] step_col(input logic [COL_W-1:0] c,
                                                  input logic [COL_W-1:0] m);
        logic [COL_W-1:0] inc;
        inc = c + 1'b1;
        return (c & ~m) | (inc & m);
    endfunction
endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
    import sdr_wr_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int AP_BIT = 10
) (
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    output logic              is_wr,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_ap
);
    logic unused_addr_bits;

    always_comb begin
        is_wr    = cke && !cs_n && ras_n && !cas_n && !we_n;
        cmd_bank = ba;
        cmd_col  = addr[COL_W-1:0];
        cmd_ap   = addr[AP_BIT];
    end

    assign unused_addr_bits = ^addr[AP_BIT-1:COL_W];
endmodule

// File: rtl/sdr_burst_ctrl.sv
module sdr_burst_ctrl
    import sdr_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              is_wr,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_ap,
    input  logic [BSEL_W-1:0] burst_sel,
    output logic              wr_vld,
    output logic [BANK_W-1:0] wr_bank,
    output logic [COL_W-1:0]  wr_col,
    output logic              pre_req,
    output logic [BANK_W-1:0] pre_bank
);
    burst_t st_d, st_q;
    logic [COL_W-1:0] new_mask;
    logic             new_full;

    always_comb begin
        st_d     = st_q;
        st_d.pre = 1'b0;
        wr_vld   = 1'b0;
        wr_bank  = st_q.bank;
        wr_col   = st_q.col;
        new_mask = blk_mask(burst_sel);
        new_full = (burst_sel == SEL_PAGE);

        if (is_wr) begin
            wr_vld      = 1'b1;
            wr_bank     = cmd_bank;
            wr_col      = cmd_col;
            st_d.bank   = cmd_bank;
            st_d.ap     = cmd_ap;
            st_d.mask   = new_mask;
            st_d.full   = new_full;
            st_d.col    = step_col(cmd_col, new_mask);
            st_d.remain = new_mask[CNT_W-1:0];
            st_d.active = new_full || (new_mask != '0);
            if (!new_full && new_mask == '0 && cmd_ap) begin
                st_d.pre      = 1'b1;
                st_d.pre_bank = cmd_bank;
            end
        end else if (st_q.active && cke) begin
            wr_vld   = 1'b1;
            st_d.col = step_col(st_q.col, st_q.mask);
            if (!st_q.full) begin
                st_d.remain = st_q.remain - 1'b1;
                if (st_q.remain == CNT_W'(1)) begin
                    st_d.active = 1'b0;
                    if (st_q.ap) begin
                        st_d.pre      = 1'b1;
                        st_d.pre_bank = st_q.bank;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pre_req  = st_q.pre;
    assign pre_bank = st_q.pre_bank;

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !is_wr) |-> !wr_vld);

    assert_page_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.full && !is_wr && cke && $past(wr_vld))
            |-> (wr_col == COL_W'($past(wr_col) + 1'b1)));

    assert_remain_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !st_q.full) |-> (st_q.remain != '0 && COL_W'(st_q.remain) <= st_q.mask));

    assert_pre_after_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pre_req |-> $past(wr_vld));

    assert_pause_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> !wr_vld);
endmodule

// File: rtl/sdr_bank_array.sv
module sdr_bank_array
    import sdr_wr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              wr_vld,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] bank_rd [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DATA_W-1:0] cells [NCOL];

        always_ff @(posedge clk) begin
            if (wr_vld && wr_bank == BANK_W'(b)) cells[wr_col] <= wr_data;
        end

        assign bank_rd[b] = cells[rd_col];
    end

    assign rd_data = bank_rd[rd_bank];
endmodule

// File: rtl/sdr_wr_burst.sv
module sdr_wr_burst
    import sdr_wr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BSEL_W-1:0] burst_sel,
    input  logic [DATA_W-1:0] dq_in,
    output logic              wr_vld,
    output logic [BANK_W-1:0] wr_bank,
    output logic [COL_W-1:0]  wr_col,
    output logic [DATA_W-1:0] wr_data,
    output logic              pre_req,
    output logic [BANK_W-1:0] pre_bank,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data
);
    logic              is_wr;
    logic [BANK_W-1:0] cmd_bank;
    logic [COL_W-1:0]  cmd_col;
    logic              cmd_ap;

    sdr_cmd_decode #(.ADDR_W(ADDR_W), .AP_BIT(10)) u_dec (
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .is_wr(is_wr), .cmd_bank(cmd_bank),
        .cmd_col(cmd_col), .cmd_ap(cmd_ap)
    );

    sdr_burst_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cke(cke), .is_wr(is_wr),
        .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
        .burst_sel(burst_sel), .wr_vld(wr_vld), .wr_bank(wr_bank),
        .wr_col(wr_col), .pre_req(pre_req), .pre_bank(pre_bank)
    );

    assign wr_data = dq_in;

    sdr_bank_array #(.DATA_W(DATA_W)) u_arr (
        .clk(clk), .wr_vld(wr_vld), .wr_bank(wr_bank), .wr_col(wr_col),
        .wr_data(dq_in), .rd_bank(rd_bank), .rd_col(rd_col), .rd_data(rd_data)
    );

    assert_cmd_first_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |-> (wr_vld && wr_col == addr[COL_W-1:0] && wr_bank == ba));
endmodule

// File: tb/sdr_wr_burst_tb.sv
module sdr_wr_burst_tb;
    localparam int DW = 32;
    localparam int NV = 6;
    // entry: {ba[13:12], ap[11], burst_sel[10:8], col[7:0]}
    localparam logic [13:0] VEC [NV] = '{
        {2'd0, 1'b0, 3'd0, 8'h05},
        {2'd1, 1'b1, 3'd1, 8'h13},
        {2'd2, 1'b0, 3'd2, 8'h26},
        {2'd3, 1'b1, 3'd3, 8'h7D},
        {2'd0, 1'b1, 3'd0, 8'h40},
        {2'd1, 1'b0, 3'd5, 8'h90}
    };

    logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
    logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0, rd_bank = '0, wr_bank, pre_bank;
    logic [10:0] addr = '0;
    logic [2:0] burst_sel = '0;
    logic [DW-1:0] dq_in = '0, wr_data, rd_data;
    logic wr_vld, pre_req;
    logic [7:0] wr_col, rd_col = '0;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sdr_wr_burst u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .burst_sel(burst_sel),
        .dq_in(dq_in), .wr_vld(wr_vld), .wr_bank(wr_bank), .wr_col(wr_col),
        .wr_data(wr_data), .pre_req(pre_req), .pre_bank(pre_bank),
        .rd_bank(rd_bank), .rd_col(rd_col), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc_raw(input logic ck, input logic cs, input logic ras, input logic cas,
                           input logic we, input logic [1:0] b, input logic [10:0] a,
                           input logic [2:0] bs, input logic [31:0] d);
        @(negedge clk);
        cke = ck; cs_n = cs; ras_n = ras; cas_n = cas; we_n = we;
        ba = b; addr = a; burst_sel = bs; dq_in = d;
        #5;
    endtask

    task automatic cyc_wr(input logic [1:0] b, input logic [7:0] c, input logic ap,
                          input logic [2:0] bs, input logic [31:0] d);
        cyc_raw(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, b, {ap, 2'b00, c}, bs, d);
    endtask

    task automatic cyc_nop(input logic [31:0] d);
        cyc_raw(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 11'd0, 3'd0, d);
    endtask

    task automatic rd_chk(input logic [1:0] b, input logic [7:0] c,
                          input logic [31:0] exp, input string req);
        rd_bank = b; rd_col = c;
        #1;
        chk(rd_data === exp, req, "array word", rd_data, exp);
    endtask

    function automatic int blen(input logic [2:0] bs);
        case (bs)
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] exp_col(input logic [7:0] s, input int len, input int i);
        logic [7:0] m, n;
        m = 8'(len - 1);
        n = s + 8'(i);
        return (s & ~m) | (n & m);
    endfunction

    function automatic logic [31:0] dword(input int v, input int i);
        return 32'hD000_0000 | (32'(v) << 8) | 32'(i);
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (3) cyc_nop(32'h0);
        chk(wr_vld == 1'b0, "R11", "wr_vld in reset", 32'(wr_vld), 0);
        chk(pre_req == 1'b0, "R11", "pre_req in reset", 32'(pre_req), 0);
        @(negedge clk); rst_n = 1'b1;
        cyc_nop(32'h0);
        chk(wr_vld == 1'b0, "R11", "wr_vld after reset", 32'(wr_vld), 0);

        // table walk: isolated bursts (R2 R3 R4 R5 R8)
        for (int v = 0; v < NV; v++) begin
            logic [1:0] b;
            logic ap;
            logic [2:0] bs;
            logic [7:0] c;
            int len;
            {b, ap, bs, c} = VEC[v];
            len = blen(bs);
            cyc_wr(b, c, ap, bs, dword(v, 0));
            chk(wr_vld == 1'b1, "R2", "wr_vld on command", 32'(wr_vld), 1);
            chk(wr_col == c, "R2", "first column", 32'(wr_col), 32'(c));
            chk(wr_bank == b, "R2", "first bank", 32'(wr_bank), 32'(b));
            for (int i = 1; i < len; i++) begin
                cyc_nop(dword(v, i));
                chk(wr_vld == 1'b1, "R3", "wr_vld in burst", 32'(wr_vld), 1);
                chk(wr_col == exp_col(c, len, i), "R4", "burst column",
                    32'(wr_col), 32'(exp_col(c, len, i)));
            end
            cyc_nop(32'hBAD0_0000 | 32'(v));
            chk(wr_vld == 1'b0, "R5", "wr_vld after burst", 32'(wr_vld), 0);
            chk(pre_req == ap, "R8", "pre_req after last word", 32'(pre_req), 32'(ap));
            if (ap) chk(pre_bank == b, "R8", "pre_bank", 32'(pre_bank), 32'(b));
            cyc_nop(32'hBAD1_0000);
            chk(pre_req == 1'b0, "R8", "pre_req one cycle", 32'(pre_req), 0);
            for (int i = 0; i < len; i++)
                rd_chk(b, exp_col(c, len, i), dword(v, i), "R5");
        end

        // R1: non-write commands store nothing
        cyc_raw(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 11'h005, 3'd0, 32'hEEEE_0001);
        chk(wr_vld == 1'b0, "R1", "we_n high", 32'(wr_vld), 0);
        cyc_raw(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 11'h005, 3'd0, 32'hEEEE_0002);
        chk(wr_vld == 1'b0, "R1", "cs_n high", 32'(wr_vld), 0);
        cyc_nop(32'h0);
        chk(wr_vld == 1'b0, "R1", "no burst started", 32'(wr_vld), 0);
        rd_chk(2'd0, 8'h05, dword(0, 0), "R1");

        // R10: cke low ignores command and pauses burst
        cyc_raw(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 11'h005, 3'd0, 32'hEEEE_0003);
        chk(wr_vld == 1'b0, "R10", "write with cke low", 32'(wr_vld), 0);
        cyc_wr(2'd3, 8'h10, 1'b1, 3'd2, 32'hA000_0000);
        cyc_raw(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 11'd0, 3'd0, 32'hEEEE_0004);
        chk(wr_vld == 1'b0, "R10", "paused cycle", 32'(wr_vld), 0);
        for (int i = 1; i < 4; i++) begin
            cyc_nop(32'hA000_0000 | 32'(i));
            chk(wr_col == 8'(8'h10 + i), "R10", "resumed column", 32'(wr_col), 32'(8'h10 + i));
        end
        cyc_nop(32'hEEEE_0005);
        chk(pre_req == 1'b1 && pre_bank == 2'd3, "R8", "pre after paused burst",
            {pre_req, 29'd0, pre_bank}, {1'b1, 29'd0, 2'd3});
        rd_chk(2'd3, 8'h11, 32'hA000_0001, "R10");

        // R7 / R9: truncation by a WRITE to another bank
        cyc_wr(2'd2, 8'h50, 1'b1, 3'd3, 32'hB000_0000);
        cyc_nop(32'hB000_0001);
        cyc_wr(2'd1, 8'hA0, 1'b0, 3'd1, 32'hC000_0000);
        chk(wr_vld && wr_bank == 2'd1 && wr_col == 8'hA0, "R7", "new burst start",
            {22'd0, wr_bank, wr_col}, {22'd0, 2'd1, 8'hA0});
        cyc_nop(32'hC000_0001);
        chk(wr_col == 8'hA1 && wr_bank == 2'd1, "R7", "new burst second word",
            32'(wr_col), 32'hA1);
        cyc_nop(32'hEEEE_0006);
        chk(wr_vld == 1'b0, "R7", "truncated burst stopped", 32'(wr_vld), 0);
        chk(pre_req == 1'b0, "R9", "no pre on truncation", 32'(pre_req), 0);
        cyc_nop(32'h0);
        chk(pre_req == 1'b0, "R9", "still no pre", 32'(pre_req), 0);
        rd_chk(2'd1, 8'hA0, 32'hC000_0000, "R7");

        // R7: back-to-back same bank
        cyc_wr(2'd0, 8'h20, 1'b0, 3'd0, 32'hD100_0000);
        cyc_wr(2'd0, 8'h21, 1'b0, 3'd0, 32'hD100_0001);
        chk(wr_vld && wr_col == 8'h21, "R7", "gapless same bank", 32'(wr_col), 32'h21);
        cyc_nop(32'h0);
        rd_chk(2'd0, 8'h20, 32'hD100_0000, "R7");
        rd_chk(2'd0, 8'h21, 32'hD100_0001, "R7");

        // R6: full page wraps and runs until terminated
        cyc_wr(2'd1, 8'hFE, 1'b1, 3'd7, 32'hE000_0000);
        for (int i = 1; i < 10; i++) begin
            cyc_nop(32'hE000_0000 | 32'(i));
            chk(wr_vld && wr_col == 8'(8'hFE + i), "R6", "page column",
                32'(wr_col), 32'(8'(8'hFE + i)));
        end
        cyc_wr(2'd1, 8'h30, 1'b0, 3'd0, 32'hF000_0000);
        chk(wr_col == 8'h30, "R7", "page terminated by write", 32'(wr_col), 32'h30);
        cyc_nop(32'hEEEE_0007);
        chk(wr_vld == 1'b0, "R6", "page stopped", 32'(wr_vld), 0);
        chk(pre_req == 1'b0, "R9", "no pre on ended page", 32'(pre_req), 0);
        rd_chk(2'd1, 8'h00, 32'hE000_0002, "R6");
        rd_chk(2'd1, 8'hFF, 32'hE000_0001, "R6");

        // R11: reset during a burst
        cyc_wr(2'd2, 8'h60, 1'b1, 3'd7, 32'h1111_0000);
        @(negedge clk);
        rst_n = 1'b0; cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        #5;
        chk(wr_vld == 1'b0, "R11", "burst cleared by reset", 32'(wr_vld), 0);
        @(negedge clk); rst_n = 1'b1;
        cyc_nop(32'h0);
        chk(wr_vld == 1'b0 && pre_req == 1'b0, "R11", "idle after reset",
            {31'd0, wr_vld}, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule